// File: doc/BRIEF.md
# Self-Routing Banyan Packet Fabric

This block moves one word per port per cycle from N input ports to N output ports through log2(N) columns of 2x2 steering elements. No central scheduler decides the paths. Each arriving word carries a destination port number in binary. On entry the fabric fastens that number to the word as a routing tag. Each column reads one bit of the tag to decide whether a word leaves its element on the upper or the lower side. After the last column the tag is removed, and the bare data word appears on the port the tag named.

Every element checks its own two inputs. Suppose both inputs hold valid words that want the same side. The word on the upper input continues, the word on the lower input is discarded, and the flag for that element is raised. A column is combinational and ends in one register, so a word spends exactly log2(N) cycles in the fabric. A new set of words may enter on every cycle.

Top module: `banyan_fabric`

## Requirements
- R1: After reset, every bit of `out_valid` and `collision` is 0 until valid words have travelled through the fabric.
- R2: A valid word on input i is routed by its tag `in_tag[i*TAG_W +: TAG_W]`. If it loses no conflict on the way, it leaves on the output port whose number equals that tag.
- R3: The routing tag is removed before the word leaves. `out_data[p*DATA_W +: DATA_W]` equals the data word that entered, bit for bit.
- R4: A word presented in the cycle before clock edge k appears on the outputs after edge k+log2(PORTS)-1. Before that, the outputs show nothing from it. Consecutive cycles may carry independent sets of words.
- R5: Input port i enters line i. Column s (s=0 is the input column) pairs lines that differ only in bit TAG_W-1-s, and it examines tag bit TAG_W-1-s. So the most significant bit is examined first. A word takes the lower-numbered line of its pair when that bit is 0 and the higher-numbered line when it is 1. Two valid words at one element that examine different bit values both pass.
- R6: Two valid words at one element with equal examined bits form a conflict. The word from the lower-numbered line survives and the other is dropped. Flag bit `collision[s*(PORTS/2)+e]` is 1 for exactly the one cycle after edge s+1 of that wave. Here e is the lower line number with bit TAG_W-1-s removed.
- R7: An input whose valid bit is 0 takes no element output and never raises a flag, whatever its tag and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | PORTS | Word present on each input port |
| in_tag | input | PORTS*log2(PORTS) | Destination port number for each input, packed by port |
| in_data | input | PORTS*DATA_W | Data word for each input, packed by port |
| out_valid | output | PORTS | Word present on each output port |
| out_data | output | PORTS*DATA_W | Data word on each output port, with the tag removed |
| collision | output | log2(PORTS)*PORTS/2 | Per-element conflict flags, column-major |

## Verification
The hardest case to reach from the ports is a conflict deep in the fabric. A clash in the middle or last column only happens when two words agree on the low bits of their source ports and on the high bits of their destinations. By then their paths have already merged in earlier columns. The stimulus picks input pairs and tags by hand so that a conflict lands on a chosen column and element, and the bench checks the flag bit in the single cycle it should be high. It also checks which word reached the shared destination port. Further waves pair a valid word with an idle input that names the same destination, and send two full permutations on back-to-back cycles.

// File: rtl/banyan_pkg.sv
package banyan_pkg;

   // Lower-numbered line of the pair served by element 'elem' in the column
   // that examines line bit 'bitpos': insert a 0 at that bit position.
   function automatic int upper_line(input int elem, input int bitpos);
      int lo_part;
      int hi_part;
      lo_part = elem & ((1 << bitpos) - 1);
      hi_part = (elem >> bitpos) << (bitpos + 1);
      return hi_part | lo_part;
   endfunction

   // Tag bit examined by column 'col' of a fabric with 'tag_w' tag bits.
   function automatic int column_bit(input int col, input int tag_w);
      return tag_w - 1 - col;
   endfunction

endpackage

// File: rtl/banyan_elem.sv
module banyan_elem #(
   parameter int unsigned WORD_W  = 19,
   parameter int unsigned SEL_BIT = 18
) (
   input  logic              up_vld,
   input  logic [WORD_W-1:0] up_word,
   input  logic              dn_vld,
   input  logic [WORD_W-1:0] dn_word,
   output logic              o0_vld,
   output logic [WORD_W-1:0] o0_word,
   output logic              o1_vld,
   output logic [WORD_W-1:0] o1_word,
   output logic              clash
);

   if (SEL_BIT >= WORD_W) begin : g_bad_sel
      $error("banyan_elem: SEL_BIT outside the word");
   end

   logic up_b;
   logic dn_b;

   assign up_b  = up_word[SEL_BIT];
   assign dn_b  = dn_word[SEL_BIT];
   assign clash = up_vld & dn_vld & (up_b == dn_b);

   // Lower input is placed first; the upper input then overrides its side,
   // which gives the upper input priority on a conflict.
   always_comb begin
      o0_vld  = 1'b0;
      o1_vld  = 1'b0;
      o0_word = '0;
      o1_word = '0;
      if (dn_vld) begin
         if (dn_b) begin
            o1_vld  = 1'b1;
            o1_word = dn_word;
         end else begin
            o0_vld  = 1'b1;
            o0_word = dn_word;
         end
      end
      if (up_vld) begin
         if (up_b) begin
            o1_vld  = 1'b1;
            o1_word = up_word;
         end else begin
            o0_vld  = 1'b1;
            o0_word = up_word;
         end
      end
   end

endmodule

// File: rtl/banyan_stage.sv
module banyan_stage #(
   parameter int unsigned PORTS   = 8,
   parameter int unsigned WORD_W  = 19,
   parameter int unsigned TAG_W   = 3,
   parameter int unsigned TAG_LSB = 16,
   parameter int unsigned COLUMN  = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [PORTS-1:0]             in_vld,
   input  logic [PORTS-1:0][WORD_W-1:0] in_word,
   output logic [PORTS-1:0]             out_vld,
   output logic [PORTS-1:0][WORD_W-1:0] out_word,
   output logic [PORTS/2-1:0]           clash_q
);

   localparam int ELEMS = PORTS / 2;
   localparam int LB    = banyan_pkg::column_bit(COLUMN, TAG_W);
   localparam int SEL   = TAG_LSB + LB;

   if (COLUMN >= TAG_W) begin : g_bad_column
      $error("banyan_stage: COLUMN beyond the tag width");
   end
   if (TAG_LSB + TAG_W > WORD_W) begin : g_bad_tag
      $error("banyan_stage: tag field outside the word");
   end

   logic              nxt_v [PORTS];
   logic [WORD_W-1:0] nxt_w [PORTS];
   logic              nxt_c [ELEMS];

   for (genvar e = 0; e < ELEMS; e++) begin : g_elem
      localparam int LO = banyan_pkg::upper_line(e, LB);
      localparam int HI = LO + (1 << LB);

      banyan_elem #(
         .WORD_W (WORD_W),
         .SEL_BIT(SEL)
      ) u_elem (
         .up_vld (in_vld[LO]),
         .up_word(in_word[LO]),
         .dn_vld (in_vld[HI]),
         .dn_word(in_word[HI]),
         .o0_vld (nxt_v[LO]),
         .o0_word(nxt_w[LO]),
         .o1_vld (nxt_v[HI]),
         .o1_word(nxt_w[HI]),
         .clash  (nxt_c[e])
      );

      // R7: a flag needs two valid words at the element one cycle earlier
      a_r7_flag_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && clash_q[e]) |-> $past(in_vld[LO] && in_vld[HI]));

      // R6: on a conflict the upper word is found on one side of the pair
      a_r6_upper_survives: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && clash_q[e]) |->
            ((out_vld[LO] && out_word[LO] == $past(in_word[LO])) ||
             (out_vld[HI] && out_word[HI] == $past(in_word[LO]))));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= '0;
         out_word <= '0;
         clash_q  <= '0;
      end else begin
         for (int i = 0; i < PORTS; i++) begin
            out_vld[i]  <= nxt_v[i];
            out_word[i] <= nxt_w[i];
         end
         for (int e = 0; e < ELEMS; e++) begin
            clash_q[e] <= nxt_c[e];
         end
      end
   end

   // R5: after this column, a word sits on the line whose bit matches its tag
   for (genvar i = 0; i < PORTS; i++) begin : g_line_chk
      a_r5_line_bit: assert property (@(posedge clk) disable iff (!rst_n)
         out_vld[i] |-> (out_word[i][SEL] == (((i >> LB) & 1) == 1)));
   end

   // R6: each dropped word is matched by exactly one raised flag
   a_r6_words_conserved: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |->
         ($countones(out_vld) + $countones(clash_q) == $past($countones(in_vld))));

endmodule

// File: rtl/banyan_fabric.sv
module banyan_fabric #(
   parameter int unsigned PORTS  = 8,
   parameter int unsigned DATA_W = 16
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic [PORTS-1:0]                          in_valid,
   input  logic [PORTS*$clog2(PORTS)-1:0]            in_tag,
   input  logic [PORTS*DATA_W-1:0]                   in_data,
   output logic [PORTS-1:0]                          out_valid,
   output logic [PORTS*DATA_W-1:0]                   out_data,
   output logic [$clog2(PORTS)*(PORTS/2)-1:0]        collision
);

   localparam int TAG_W  = $clog2(PORTS);
   localparam int STAGES = TAG_W;
   localparam int ELEMS  = PORTS / 2;
   localparam int WORD_W = DATA_W + TAG_W;

   if (PORTS < 2 || (1 << TAG_W) != PORTS) begin : g_bad_ports
      $error("banyan_fabric: PORTS must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("banyan_fabric: DATA_W must be at least 1");
   end

   logic [PORTS-1:0]             st_v [STAGES+1];
   logic [PORTS-1:0][WORD_W-1:0] st_w [STAGES+1];

   // Tag attach: routing tag is placed above the data word
   for (genvar p = 0; p < PORTS; p++) begin : g_attach
      assign st_w[0][p] = {in_tag[p*TAG_W +: TAG_W], in_data[p*DATA_W +: DATA_W]};
   end
   assign st_v[0] = in_valid;

   for (genvar s = 0; s < STAGES; s++) begin : g_col
      banyan_stage #(
         .PORTS  (PORTS),
         .WORD_W (WORD_W),
         .TAG_W  (TAG_W),
         .TAG_LSB(DATA_W),
         .COLUMN (s)
      ) u_stage (
         .clk     (clk),
         .rst_n   (rst_n),
         .in_vld  (st_v[s]),
         .in_word (st_w[s]),
         .out_vld (st_v[s+1]),
         .out_word(st_w[s+1]),
         .clash_q (collision[s*ELEMS +: ELEMS])
      );
   end

   // Tag strip: only the data field leaves the fabric
   for (genvar p = 0; p < PORTS; p++) begin : g_strip
      assign out_data[p*DATA_W +: DATA_W] = st_w[STAGES][p][DATA_W-1:0];

      // R2: a word leaving port p carried tag p
      a_r2_exit_matches_tag: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[p] |-> (st_w[STAGES][p][DATA_W +: TAG_W] == TAG_W'(p)));
   end
   assign out_valid = st_v[STAGES];

endmodule

// File: tb/tb_banyan_fabric.sv
module tb_banyan_fabric;

   localparam int P   = 8;
   localparam int DW  = 16;
   localparam int TW  = 3;
   localparam int NS  = 3;
   localparam int NE  = P / 2;
   localparam int CLK_PERIOD = 10;

   logic              clk;
   logic              rst_n;
   logic [P-1:0]      in_valid;
   logic [P*TW-1:0]   in_tag;
   logic [P*DW-1:0]   in_data;
   logic [P-1:0]      out_valid;
   logic [P*DW-1:0]   out_data;
   logic [NS*NE-1:0]  collision;

   int checks;
   int failures;
   bit done;

   logic [P-1:0]     exp_v;
   logic [DW-1:0]    exp_d [P];
   logic [NS*NE-1:0] exp_c;

   banyan_fabric #(.PORTS(P), .DATA_W(DW)) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_tag   (in_tag),
      .in_data  (in_data),
      .out_valid(out_valid),
      .out_data (out_data),
      .collision(collision)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input string what,
                        input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
      end
   endtask

   task automatic clear_in();
      in_valid = '0;
      in_tag   = '0;
      in_data  = '0;
   endtask

   task automatic put(input int port, input bit vld, input int tag, input logic [DW-1:0] d);
      in_valid[port]         = vld;
      in_tag[port*TW +: TW]  = TW'(tag);
      in_data[port*DW +: DW] = d;
   endtask

   task automatic clear_exp();
      exp_v = '0;
      exp_c = '0;
      for (int i = 0; i < P; i++) exp_d[i] = '0;
   endtask

   task automatic expect_out(input int port, input logic [DW-1:0] d);
      exp_v[port] = 1'b1;
      exp_d[port] = d;
   endtask

   task automatic check_ports(input string req);
      check(req, "out_valid", 64'(out_valid), 64'(exp_v));
      for (int p = 0; p < P; p++) begin
         if (exp_v[p]) check(req, $sformatf("out_data[%0d]", p),
                             64'(out_data[p*DW +: DW]), 64'(exp_d[p]));
      end
   endtask

   // Inputs are already driven; walks the wave through every column.
   task automatic run_wave(input string req);
      logic [NS*NE-1:0] mask;
      for (int k = 1; k <= NS; k++) begin
         @(negedge clk);
         if (k == 1) clear_in();
         mask = '0;
         mask[(k-1)*NE +: NE] = '1;
         check({req, " R6"}, $sformatf("collision after edge %0d", k),
               64'(collision), 64'(exp_c & mask));
         if (k < NS) check({req, " R4"}, $sformatf("out_valid early at edge %0d", k),
                           64'(out_valid), 64'h0);
         else check_ports(req);
      end
   endtask

   task automatic t_reset();
      check("R1", "out_valid after reset", 64'(out_valid), 64'h0);
      check("R1", "collision after reset", 64'(collision), 64'h0);
   endtask

   task automatic t_identity();
      clear_exp();
      for (int i = 0; i < P; i++) begin
         put(i, 1'b1, i, 16'hA100 + 16'(i));
         expect_out(i, 16'hA100 + 16'(i));
      end
      run_wave("R2 R3 R5 identity");
   endtask

   task automatic t_xor();
      clear_exp();
      for (int i = 0; i < P; i++) begin
         put(i, 1'b1, i ^ 5, 16'hB200 + 16'(i));
         expect_out(i ^ 5, 16'hB200 + 16'(i));
      end
      run_wave("R2 R3 xor5");
   endtask

   task automatic t_single();
      clear_exp();
      put(3, 1'b1, 6, 16'h5EC3);
      expect_out(6, 16'h5EC3);
      run_wave("R2 R4 single");
   endtask

   task automatic t_coll_first();
      clear_exp();
      put(0, 1'b1, 2, 16'hC0A0);
      put(4, 1'b1, 3, 16'hC0A4);
      expect_out(2, 16'hC0A0);
      exp_c[0*NE + 0] = 1'b1;
      run_wave("R6 R5 first column");
   endtask

   task automatic t_coll_mid();
      clear_exp();
      put(0, 1'b1, 0, 16'hD1D0);
      put(2, 1'b1, 1, 16'hD1D2);
      expect_out(0, 16'hD1D0);
      exp_c[1*NE + 0] = 1'b1;
      run_wave("R6 middle column");
   endtask

   task automatic t_coll_last();
      clear_exp();
      put(0, 1'b1, 1, 16'hE2E0);
      put(1, 1'b1, 1, 16'hE2E1);
      expect_out(1, 16'hE2E0);
      exp_c[2*NE + 0] = 1'b1;
      run_wave("R6 last column");
   endtask

   task automatic t_idle_rival();
      clear_exp();
      put(0, 1'b1, 2, 16'hF0F0);
      put(4, 1'b0, 3, 16'hBAD4);
      put(1, 1'b0, 2, 16'hBAD1);
      expect_out(2, 16'hF0F0);
      run_wave("R7 idle rival");
   endtask

   task automatic t_lower_alone();
      clear_exp();
      put(0, 1'b0, 2, 16'hBAD0);
      put(4, 1'b1, 3, 16'h7704);
      expect_out(3, 16'h7704);
      run_wave("R7 R2 lower alone");
   endtask

   task automatic t_pipeline();
      @(negedge clk);
      for (int i = 0; i < P; i++) put(i, 1'b1, i, 16'h3300 + 16'(i));
      @(negedge clk);
      for (int i = 0; i < P; i++) put(i, 1'b1, i ^ 7, 16'h4400 + 16'(i));
      @(negedge clk);
      clear_in();
      check("R4 pipeline", "out_valid before first wave", 64'(out_valid), 64'h0);
      @(negedge clk);
      clear_exp();
      for (int i = 0; i < P; i++) expect_out(i, 16'h3300 + 16'(i));
      check_ports("R4 pipeline wave A");
      check("R4 pipeline", "collision wave A", 64'(collision), 64'h0);
      @(negedge clk);
      clear_exp();
      for (int i = 0; i < P; i++) expect_out(i ^ 7, 16'h4400 + 16'(i));
      check_ports("R4 pipeline wave B");
      @(negedge clk);
      check("R4 pipeline", "out_valid drained", 64'(out_valid), 64'h0);
   endtask

   initial begin
      checks   = 0;
      failures = 0;
      done     = 1'b0;
      clear_in();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_identity();
      t_xor();
      t_single();
      t_coll_first();
      t_coll_mid();
      t_coll_last();
      t_idle_rival();
      t_lower_alone();
      t_pipeline();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog run did not complete got=hung exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule